// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Buffer and Status Flags

This block receives asynchronous serial characters on a single input line. The line is sampled at sixteen times the bit rate, paced by an external sample tick. A falling edge starts a character, and the start bit must still read low at mid-bit for reception to go on. Each data bit is decided by a majority vote over three samples around its centre. Characters are 8 or 9 data bits, least significant bit first, followed by one stop bit.

A finished character moves into a byte-wide receive buffer, and a status register reports four flags: buffer full, overrun, framing error and idle line. The flags are cleared by a two-step read: first the status register is read while a flag is set, then the data register is read. One interrupt request output combines the flags under two enables.

The read port is a plain select/strobe pair with combinational read data. The buffer contents survive reset; only the flags and control state return to their reset values.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset the status register reads 0 and `irq` is low. Status bit positions: bit0 full, bit1 overrun, bit2 framing error, bit3 idle, bit4 ninth data bit; all other bits read 0.
- R2: In 8-bit mode (`nine_mode`=0) a character with a high stop bit places its 8 data bits, first received in bit0, in the data register (`rd_sel`=0). It also sets the full flag, with the framing flag clear.
- R3: A character whose stop bit samples low sets the framing flag in the same cycle as the full flag for that character.
- R4: A character completing while the full flag is set sets the overrun flag, is discarded, and leaves the earlier buffered byte unchanged.
- R5: A status read (`rd_en`=1, `rd_sel`=1) made while any flag is set, followed by a data read, clears all four flags. A data read with no such status read before it leaves the flags unchanged.
- R6: In 9-bit mode 9 data bits are received; the first eight go to the data register and the last one to status bit4.
- R7: A low pulse on the line that has returned high by mid-bit is rejected as a start bit and produces no character.
- R9: Once armed, the idle flag sets after 10 bit times (160 ticks) of continuous high line in 8-bit mode, or after 11 bit times (176 ticks) in 9-bit mode, counted from the end of the last character.
- R10: Idle detection is armed only by a received character; it is not armed after reset, and it is disarmed each time the idle flag sets.
- R11: `irq` = (`rx_ie` AND (full OR overrun)) OR (`idle_ie` AND idle).
- R12: Reset does not alter the contents of the data register.
- R13: Bit timing follows `os_tick`: with a tick every third clock, a character lasting 48 clocks per bit is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Sample strobe at 16x bit rate |
| nine_mode | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rx_ie | input | 1 | Interrupt enable for full and overrun |
| idle_ie | input | 1 | Interrupt enable for idle |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 1 reads status, 0 reads data |
| rd_data | output | 8 | Read data of the selected register |
| irq | output | 1 | Receiver interrupt request |

## Verification
Assertions check on every cycle that a framing flag only rises together with a full buffer at a character completion, and that an overrun only rises while the buffer is full and leaves its contents untouched. They also check that the full flag only falls after an armed data read, and that idle pulses occur only on a high line. The bench scenarios are what show that the right bits land in the buffer in both character lengths and at a slower tick rate. They also show the exact 10- versus 11-bit idle thresholds, start-bit rejection, the enable gating of the interrupt, and that the buffer survives reset.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    localparam int unsigned ST_FULL = 0;
    localparam int unsigned ST_OVR  = 1;
    localparam int unsigned ST_FE   = 2;
    localparam int unsigned ST_IDLE = 3;
    localparam int unsigned ST_BIT8 = 4;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR   = 16,
    parameter int unsigned DBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line,
    input  logic             nine,
    output logic             done,
    output logic             stop_bad,
    output logic             busy,
    output logic [DBITS:0]   chr
);
    localparam int unsigned PW  = $clog2(OSR);
    localparam int unsigned BW  = $clog2(DBITS + 1);
    localparam int unsigned SW  = DBITS + 1;
    localparam int unsigned MID = OSR / 2;

    typedef struct packed {
        rx_state_e       state;
        logic [PW-1:0]   phase;
        logic [BW-1:0]   bitn;
        logic [SW-1:0]   sh;
        logic            s_a;
        logic            s_b;
        logic            done;
        logic            bad;
    } frm_t;

    frm_t d, q;
    logic maj;
    logic [BW-1:0] last_bit;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        maj      = (q.s_a & q.s_b) | (q.s_a & line) | (q.s_b & line);
        last_bit = nine ? BW'(DBITS) : BW'(DBITS - 1);
        if (tick) begin
            if (q.state == RX_IDLE) begin
                if (!line) begin
                    d.state = RX_START;
                    d.phase = PW'(1);
                end
            end else begin
                d.phase = (q.phase == PW'(OSR - 1)) ? '0 : q.phase + PW'(1);
                if (q.phase == PW'(MID - 1)) d.s_a = line;
                if (q.phase == PW'(MID))     d.s_b = line;
                if (q.phase == PW'(MID + 1)) begin
                    case (q.state)
                        RX_START: if (maj) d.state = RX_IDLE;
                        RX_DATA:  d.sh = {maj, q.sh[SW-1:1]};
                        RX_STOP: begin
                            d.done  = 1'b1;
                            d.bad   = !maj;
                            d.state = RX_IDLE;
                        end
                        default: ;
                    endcase
                end
                if (q.phase == PW'(OSR - 1)) begin
                    case (q.state)
                        RX_START: begin
                            d.state = RX_DATA;
                            d.bitn  = '0;
                        end
                        RX_DATA: begin
                            if (q.bitn == last_bit) d.state = RX_STOP;
                            else                    d.bitn  = q.bitn + BW'(1);
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done     = q.done;
    assign stop_bad = q.bad;
    assign busy     = (q.state != RX_IDLE);
    assign chr      = nine ? q.sh : {1'b0, q.sh[SW-1:1]};

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R2
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
    parameter int unsigned OSR   = 16,
    parameter int unsigned DBITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic quiet,
    input  logic nine,
    input  logic char_done,
    output logic hit
);
    localparam int unsigned LIM_S = OSR * (DBITS + 2);
    localparam int unsigned LIM_L = OSR * (DBITS + 3);
    localparam int unsigned CW    = $clog2(LIM_L + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
        logic          hit;
    } idl_t;

    idl_t d, q;
    logic [CW-1:0] lim;

    always_comb begin
        d     = q;
        d.hit = 1'b0;
        lim   = nine ? CW'(LIM_L) : CW'(LIM_S);
        if (char_done) d.armed = 1'b1;
        if (!line || !quiet) begin
            d.cnt = '0;
        end else if (tick) begin
            if (q.cnt < lim) d.cnt = q.cnt + CW'(1);
            if (q.armed && q.cnt == lim - CW'(1)) begin
                d.hit   = 1'b1;
                d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hit = q.hit;

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        q.hit |-> $past(line)); // R9
    AST_IDLE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        q.hit |=> !q.hit); // R10
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR   = 16,
    parameter int unsigned DBITS = 8,
    parameter int unsigned SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_in,
    input  logic             os_tick,
    input  logic             nine_mode,
    input  logic             rx_ie,
    input  logic             idle_ie,
    input  logic             rd_en,
    input  logic             rd_sel,
    output logic [DBITS-1:0] rd_data,
    output logic             irq
);
    typedef struct packed {
        logic full;
        logic ovr;
        logic fe;
        logic idle;
        logic arm;
    } flg_t;

    flg_t d, q;
    logic [DBITS:0] buf_d, buf_q;
    logic line_s, frm_done, frm_bad, frm_busy, idle_hit;
    logic [DBITS:0] frm_chr;
    logic [DBITS-1:0] status_v;

    uart_rx_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(line_s)
    );

    uart_rx_frame #(.OSR(OSR), .DBITS(DBITS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s),
        .nine(nine_mode), .done(frm_done), .stop_bad(frm_bad),
        .busy(frm_busy), .chr(frm_chr)
    );

    uart_rx_idle #(.OSR(OSR), .DBITS(DBITS)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s),
        .quiet(!frm_busy), .nine(nine_mode), .char_done(frm_done),
        .hit(idle_hit)
    );

    always_comb begin
        d     = q;
        buf_d = buf_q;
        if (rd_en && rd_sel && (q.full || q.ovr || q.fe || q.idle))
            d.arm = 1'b1;
        if (rd_en && !rd_sel && q.arm) begin
            d.full = 1'b0;
            d.ovr  = 1'b0;
            d.fe   = 1'b0;
            d.idle = 1'b0;
            d.arm  = 1'b0;
        end
        if (frm_done) begin
            if (d.full) begin
                d.ovr = 1'b1;
            end else begin
                buf_d  = frm_chr;
                d.full = 1'b1;
                d.fe   = frm_bad;
            end
        end
        if (idle_hit) d.idle = 1'b1;
    end

    always_comb begin
        status_v          = '0;
        status_v[ST_FULL] = q.full;
        status_v[ST_OVR]  = q.ovr;
        status_v[ST_FE]   = q.fe;
        status_v[ST_IDLE] = q.idle;
        status_v[ST_BIT8] = buf_q[DBITS];
        if (!q.full && !q.ovr) status_v[ST_BIT8] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        buf_q <= buf_d;
    end

    assign rd_data = rd_sel ? status_v : buf_q[DBITS-1:0];
    assign irq     = (rx_ie && (q.full || q.ovr)) || (idle_ie && q.idle);

    AST_FE_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.fe) |-> (q.full && $past(frm_done))); // R3
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> $past(q.full)); // R4
    AST_OVR_HOLDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> (buf_q == $past(buf_q))); // R4
    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.full) |-> $past(q.arm && rd_en && !rd_sel)); // R5
    AST_FULL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !q.full) |=> q.full); // R2
endmodule

// File: tb/uart_rx_flags_test.sv
module uart_rx_flags_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0, rx_in = 1, os_tick = 0, nine_mode = 0;
    logic rx_ie = 0, idle_ie = 0, rd_en = 0, rd_sel = 0;
    logic [7:0] rd_data;
    logic irq;

    int n_chk = 0, n_fail = 0, tick_div = 1, tick_cnt = 0;
    bit mon_en = 0, done_flag = 0;
    logic [7:0] v;

    typedef struct {
        logic [8:0] ch;
        logic       fe;
        string      tag;
    } item_t;
    item_t exp_q[$];

    uart_rx_flags uut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
        .nine_mode(nine_mode), .rx_ie(rx_ie), .idle_ie(idle_ie),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick_cnt++;
            if (tick_cnt >= tick_div) begin
                tick_cnt = 0;
                os_tick  = 1;
            end else begin
                os_tick = 0;
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic sel, output logic [7:0] val);
        rd_sel = sel;
        rd_en  = 1;
        #1 val = rd_data;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic send_frame(input logic [8:0] ch, input logic nine, input logic stop_ok);
        int bitc;
        int nb;
        bitc = 16 * tick_div;
        nb   = nine ? 9 : 8;
        @(negedge clk);
        rx_in = 0;
        repeat (bitc) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx_in = ch[i];
            repeat (bitc) @(negedge clk);
        end
        rx_in = stop_ok;
        repeat (bitc) @(negedge clk);
        rx_in = 1;
        repeat (bitc) @(negedge clk);
    endtask

    task automatic push_send(input logic [8:0] ch, input logic nine, input logic stop_ok, input string tag);
        item_t it;
        it.ch  = nine ? ch : {1'b0, ch[7:0]};
        it.fe  = !stop_ok;
        it.tag = tag;
        exp_q.push_back(it);
        send_frame(ch, nine, stop_ok);
    endtask

    task automatic flush_flags();
        logic [7:0] t;
        bus_read(1, t);
        bus_read(0, t);
    endtask

    // monitor: pops expected characters as the design reports them
    initial begin
        logic [7:0] s, dv;
        item_t it;
        forever begin
            @(negedge clk);
            if (mon_en && irq) begin
                bus_read(1, s);
                bus_read(0, dv);
                if (exp_q.size() == 0) begin
                    check("R2 unexpected char", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    check({it.tag, " status"}, s & 8'h17,
                          {3'b0, it.ch[8], 1'b0, it.fe, 1'b0, 1'b1});
                    check({it.tag, " data"}, dv, it.ch[7:0]);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(negedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        check("R1 status", rd_data & 8'h00, 0);
        rd_sel = 1;
        #1;
        check("R1 status", rd_data, 0);
        check("R1 irq", irq, 0);

        repeat (300) @(negedge clk);
        bus_read(1, v);
        check("R10 no idle after reset", v[3], 0);

        // scoreboard phase
        rx_ie  = 1;
        mon_en = 1;
        push_send(9'h055, 0, 1, "R2");
        push_send(9'h0A3, 0, 1, "R2");
        push_send(9'h000, 0, 1, "R2");
        push_send(9'h0FF, 0, 1, "R2");
        push_send(9'h03C, 0, 0, "R3");
        push_send(9'h0C6, 0, 1, "R3 after fe");
        nine_mode = 1;
        push_send(9'h1A5, 1, 1, "R6");
        push_send(9'h04B, 1, 1, "R6");
        nine_mode = 0;
        tick_div  = 3;
        push_send(9'h096, 0, 1, "R13");
        tick_div  = 1;
        wait (exp_q.size() == 0);
        repeat (5) @(negedge clk);
        mon_en = 0;
        check("R2 queue drained", exp_q.size(), 0);

        repeat (400) @(negedge clk);
        flush_flags();
        bus_read(1, v);
        check("R5 flags clear", v, 0);

        // interrupt gating and overrun
        send_frame(9'h05A, 0, 1);
        repeat (2) @(negedge clk);
        check("R11 irq full", irq, 1);
        rx_ie = 0;
        #1 check("R11 irq masked", irq, 0);
        rx_ie = 1;
        send_frame(9'h0C3, 0, 1);
        repeat (2) @(negedge clk);
        bus_read(0, v);
        check("R4 earlier byte kept", v, 8'h5A);
        bus_read(1, v);
        check("R4 overrun status", v, 8'h03);
        bus_read(1, v);
        check("R5 no clear without arm", v, 8'h03);
        bus_read(0, v);
        bus_read(1, v);
        check("R5 cleared after sequence", v, 0);

        // idle in 8-bit mode
        rx_ie = 0;
        send_frame(9'h011, 0, 1);
        repeat (125) @(negedge clk);
        bus_read(1, v);
        check("R9 no idle before 10 bits", v[3], 0);
        repeat (30) @(negedge clk);
        bus_read(1, v);
        check("R9 idle after 10 bits", v[3], 1);
        check("R11 idle masked", irq, 0);
        idle_ie = 1;
        #1 check("R11 idle irq", irq, 1);
        idle_ie = 0;
        flush_flags();
        repeat (300) @(negedge clk);
        bus_read(1, v);
        check("R10 not rearmed", v, 0);

        // idle in 9-bit mode
        nine_mode = 1;
        send_frame(9'h1EE, 1, 1);
        repeat (145) @(negedge clk);
        bus_read(1, v);
        check("R9 no idle before 11 bits", v[3], 0);
        repeat (30) @(negedge clk);
        bus_read(1, v);
        check("R9 idle after 11 bits", v[3], 1);
        nine_mode = 0;
        flush_flags();

        // start rejection
        rx_in = 0;
        repeat (5) @(negedge clk);
        rx_in = 1;
        repeat (300) @(negedge clk);
        bus_read(1, v);
        check("R7 glitch rejected", v, 0);

        // reset keeps buffer
        send_frame(9'h0E7, 0, 1);
        repeat (2) @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        bus_read(1, v);
        check("R1 status after reset", v, 0);
        bus_read(0, v);
        check("R12 buffer kept", v, 8'hE7);

        finish_run();
    end
endmodule